// File: doc/BRIEF.md
# Pipelined Single-Precision Float Multiplier

This block multiplies two single-precision binary floating-point words (one sign bit, an 8-bit exponent biased by 127, and a 23-bit fraction behind an implied leading one). It works in a fixed three-stage pipeline and accepts a new operand pair on every clock. It is meant to sit in front of a multiply-accumulate datapath. For that reason it never rounds. The fraction is truncated, and the product bits that fall below the kept fraction leave on a separate 24-bit extension port, so the accumulator can keep that precision.

The first stage splits the operands, flags zero operands and forms the unbiased exponent sum in a 10-bit signed field. The second stage forms the full 48-bit significand product. The third stage normalizes by at most one place and sorts the result into one of four classes: normal, zero, overflow and underflow. It then packs the output word and raises a flag for an out-of-range exponent. The pipeline has no stall and no back-pressure.

Top module: `fmul3_top`

## Requirements
- R1: For normal operands whose product stays in range, the output word carries sign in bit 31, biased exponent in bits 30:23 (a value from 1 to 254), and the truncated fraction in bits 22:0, with both flags low.
- R2: `out_valid` rises exactly three rising clock edges after the edge that samples `in_valid` high. Back-to-back inputs on consecutive cycles produce back-to-back outputs in the same order.
- R3: The result sign is the XOR of the two operand sign bits, in every result class.
- R4: When bit 47 of the 48-bit significand product is set, the fraction is taken from bits 46:24 and the exponent rises by one. Otherwise the fraction is taken from bits 45:23 and the exponent is unchanged.
- R5: `ext_bits` holds the 24 product bits directly below the kept fraction, MSB first: bits 23:0 after a shift, or bits 22:0 followed by a 0 without one. `ext_bits` is zero when the result is forced to zero or infinity.
- R6: No rounding occurs. The kept fraction is never incremented, even when `ext_bits` is half or more (bit 23 set).
- R7: A post-normalization biased exponent of 255 or more raises `ovf_flag` and forces the result to signed infinity (exponent 0xFF, fraction 0). A biased exponent of 254 does not.
- R8: A post-normalization biased exponent of 0 or less raises `unf_flag` and forces the result to signed zero. A value of 1 reached only through the normalization increment does not underflow.
- R9: An operand whose exponent field is 0 (zero or denormal) counts as zero. The result is then signed zero with both flags low and `ext_bits` zero, whatever the other operand holds.
- R10: A synchronous active-high `rst` clears every pipeline stage, so `out_valid`, `result`, `ext_bits` and both flags read 0 after the reset edge, and operands in flight at reset never emerge.
- R11: `ovf_flag` and `unf_flag` stay low whenever `out_valid` is low, even if the operands on an idle cycle would overflow or underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| out_valid | output | 1 | Result present this cycle |
| result | output | 32 | Truncated product word |
| ext_bits | output | 24 | Product bits below the kept fraction, MSB aligned |
| ovf_flag | output | 1 | Exponent overflow, result is signed infinity |
| unf_flag | output | 1 | Exponent underflow, result is signed zero |

## Verification
The assertions assume that operands never hold an all-ones exponent field (infinity or NaN), because the block gives those encodings no special meaning. They also assume that `rst` is held through at least one clock edge before the first valid input. Every operand in the vector table and in the directed tests has an exponent field from 0 to 254. Reset is raised before any stimulus and during a mid-stream test, so the shadow registers in the checker always start from a cleared pipeline.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

    // Classification chosen in the final stage before packing.
    typedef enum logic [1:0] {
        RC_NORMAL = 2'd0,
        RC_ZERO   = 2'd1,
        RC_OVF    = 2'd2,
        RC_UNF    = 2'd3
    } rclass_e;

endpackage

// File: rtl/fmul_unpack.sv
// Stage 1: split operands, detect zero operands, form unbiased exponent sum.
module fmul_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [EXP_W+FRAC_W:0]         op_a,
    input  logic [EXP_W+FRAC_W:0]         op_b,
    output logic                          s1_valid,
    output logic                          s1_sign,
    output logic                          s1_zero,
    output logic signed [EXP_W+1:0]       s1_exp,
    output logic [FRAC_W:0]               s1_sig_a,
    output logic [FRAC_W:0]               s1_sig_b
);
    localparam int EI_W = EXP_W + 2;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int TOPB = EXP_W + FRAC_W;

    logic [EXP_W-1:0]       ea, eb;
    logic                   za, zb;
    logic signed [EI_W-1:0] esum;

    always_comb begin
        ea   = op_a[FRAC_W +: EXP_W];
        eb   = op_b[FRAC_W +: EXP_W];
        za   = (ea == '0);
        zb   = (eb == '0);
        esum = $signed(EI_W'(ea)) + $signed(EI_W'(eb)) - $signed(EI_W'(BIAS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_sign  <= 1'b0;
            s1_zero  <= 1'b0;
            s1_exp   <= '0;
            s1_sig_a <= '0;
            s1_sig_b <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_sign  <= op_a[TOPB] ^ op_b[TOPB];
            s1_zero  <= za | zb;
            s1_exp   <= esum;
            s1_sig_a <= {1'b1, op_a[FRAC_W-1:0]};
            s1_sig_b <= {1'b1, op_b[FRAC_W-1:0]};
        end
    end

endmodule

// File: rtl/fmul_sigmul.sv
// Stage 2: full-width significand product; side data rides along.
module fmul_sigmul #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          s1_valid,
    input  logic                          s1_sign,
    input  logic                          s1_zero,
    input  logic signed [EXP_W+1:0]       s1_exp,
    input  logic [FRAC_W:0]               s1_sig_a,
    input  logic [FRAC_W:0]               s1_sig_b,
    output logic                          s2_valid,
    output logic                          s2_sign,
    output logic                          s2_zero,
    output logic signed [EXP_W+1:0]       s2_exp,
    output logic [2*FRAC_W+1:0]           s2_prod
);
    localparam int PROD_W = 2 * (FRAC_W + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
            s2_sign  <= 1'b0;
            s2_zero  <= 1'b0;
            s2_exp   <= '0;
            s2_prod  <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_sign  <= s1_sign;
            s2_zero  <= s1_zero;
            s2_exp   <= s1_exp;
            s2_prod  <= PROD_W'(s1_sig_a) * PROD_W'(s1_sig_b);
        end
    end

endmodule

// File: rtl/fmul_normpack.sv
// Stage 3: one-place normalization, range classification and packing.
module fmul_normpack
    import fmul_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          s2_valid,
    input  logic                          s2_sign,
    input  logic                          s2_zero,
    input  logic signed [EXP_W+1:0]       s2_exp,
    input  logic [2*FRAC_W+1:0]           s2_prod,
    output logic                          out_valid,
    output logic [EXP_W+FRAC_W:0]         result,
    output logic [FRAC_W:0]               ext_bits,
    output logic                          ovf_flag,
    output logic                          unf_flag
);
    localparam int EI_W   = EXP_W + 2;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam logic signed [EI_W-1:0] EXP_TOP = EI_W'((1 << EXP_W) - 1);
    localparam logic signed [EI_W-1:0] EXP_NIL = '0;

    logic                   shift;
    logic signed [EI_W-1:0] exp_n;
    logic [FRAC_W-1:0]      frac;
    logic [SIG_W-1:0]       ext_n;
    rclass_e                rclass;
    logic [WORD_W-1:0]      word_n;
    logic [SIG_W-1:0]       ext_q;

    always_comb begin
        shift = s2_prod[PROD_W-1];
        exp_n = s2_exp + $signed({{(EI_W-1){1'b0}}, shift});
        if (shift) begin
            frac  = s2_prod[PROD_W-2 -: FRAC_W];
            ext_n = s2_prod[SIG_W-1:0];
        end else begin
            frac  = s2_prod[PROD_W-3 -: FRAC_W];
            ext_n = {s2_prod[SIG_W-2:0], 1'b0};
        end
    end

    always_comb begin
        if (s2_zero)               rclass = RC_ZERO;
        else if (exp_n >= EXP_TOP) rclass = RC_OVF;
        else if (exp_n <= EXP_NIL) rclass = RC_UNF;
        else                       rclass = RC_NORMAL;
    end

    always_comb begin
        unique case (rclass)
            RC_NORMAL: begin
                word_n = {s2_sign, exp_n[EXP_W-1:0], frac};
                ext_q  = ext_n;
            end
            RC_OVF: begin
                word_n = {s2_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                ext_q  = '0;
            end
            RC_ZERO, RC_UNF: begin
                word_n = {s2_sign, {(WORD_W-1){1'b0}}};
                ext_q  = '0;
            end
            default: begin
                word_n = '0;
                ext_q  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            ext_bits  <= '0;
            ovf_flag  <= 1'b0;
            unf_flag  <= 1'b0;
        end else begin
            out_valid <= s2_valid;
            result    <= word_n;
            ext_bits  <= ext_q;
            ovf_flag  <= s2_valid & (rclass == RC_OVF);
            unf_flag  <= s2_valid & (rclass == RC_UNF);
        end
    end

endmodule

// File: rtl/fmul3_top.sv
module fmul3_top #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [EXP_W+FRAC_W:0]     op_a,
    input  logic [EXP_W+FRAC_W:0]     op_b,
    output logic                      out_valid,
    output logic [EXP_W+FRAC_W:0]     result,
    output logic [FRAC_W:0]           ext_bits,
    output logic                      ovf_flag,
    output logic                      unf_flag
);
    localparam int EI_W   = EXP_W + 2;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;

    logic                   s1_valid, s1_sign, s1_zero;
    logic signed [EI_W-1:0] s1_exp;
    logic [SIG_W-1:0]       s1_sig_a, s1_sig_b;
    logic                   s2_valid, s2_sign, s2_zero;
    logic signed [EI_W-1:0] s2_exp;
    logic [PROD_W-1:0]      s2_prod;

    fmul_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .s1_valid(s1_valid), .s1_sign(s1_sign), .s1_zero(s1_zero),
        .s1_exp(s1_exp), .s1_sig_a(s1_sig_a), .s1_sig_b(s1_sig_b)
    );

    fmul_sigmul #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sigmul (
        .clk(clk), .rst(rst),
        .s1_valid(s1_valid), .s1_sign(s1_sign), .s1_zero(s1_zero),
        .s1_exp(s1_exp), .s1_sig_a(s1_sig_a), .s1_sig_b(s1_sig_b),
        .s2_valid(s2_valid), .s2_sign(s2_sign), .s2_zero(s2_zero),
        .s2_exp(s2_exp), .s2_prod(s2_prod)
    );

    fmul_normpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_normpack (
        .clk(clk), .rst(rst),
        .s2_valid(s2_valid), .s2_sign(s2_sign), .s2_zero(s2_zero),
        .s2_exp(s2_exp), .s2_prod(s2_prod),
        .out_valid(out_valid), .result(result), .ext_bits(ext_bits),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

endmodule

// File: rtl/fmul3_chk.sv
module fmul3_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic                  a_sign,
    input logic                  b_sign,
    input logic                  a_ezero,
    input logic                  b_ezero,
    input logic                  out_valid,
    input logic [EXP_W+FRAC_W:0] result,
    input logic [FRAC_W:0]       ext_bits,
    input logic                  ovf_flag,
    input logic                  unf_flag
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    logic [2:0] vld_sh, sgn_sh, zro_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_sh <= '0;
            sgn_sh <= '0;
            zro_sh <= '0;
        end else begin
            vld_sh <= {vld_sh[1:0], in_valid};
            sgn_sh <= {sgn_sh[1:0], a_sign ^ b_sign};
            zro_sh <= {zro_sh[1:0], a_ezero | b_ezero};
        end
    end

    AST_NORMAL_RANGE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !ovf_flag && !unf_flag && !zro_sh[2]) |->
        (result[FRAC_W +: EXP_W] != '0 && result[FRAC_W +: EXP_W] != '1)); // R1
    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid == vld_sh[2]); // R2
    AST_SIGN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> result[WORD_W-1] == sgn_sh[2]); // R3
    AST_EXT_FORCED: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag || unf_flag) |-> ext_bits == '0); // R5
    AST_OVF_INF: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |-> (result[FRAC_W +: EXP_W] == '1 && result[FRAC_W-1:0] == '0 && !unf_flag)); // R7
    AST_UNF_ZERO: assert property (@(posedge clk) disable iff (rst)
        unf_flag |-> result[WORD_W-2:0] == '0); // R8
    AST_ZERO_IN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && zro_sh[2]) |-> (!ovf_flag && !unf_flag && result[WORD_W-2:0] == '0 && ext_bits == '0)); // R9
    AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!ovf_flag && !unf_flag)); // R11

endmodule

bind fmul3_top fmul3_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_sign(op_a[EXP_W+FRAC_W]), .b_sign(op_b[EXP_W+FRAC_W]),
    .a_ezero(op_a[FRAC_W +: EXP_W] == '0), .b_ezero(op_b[FRAC_W +: EXP_W] == '0),
    .out_valid(out_valid), .result(result), .ext_bits(ext_bits),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
);

// File: tb/fmul3_top_bench.sv
`timescale 1ns/1ps
module fmul3_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        out_valid, ovf_flag, unf_flag;
    logic [31:0] result;
    logic [23:0] ext_bits;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    fmul3_top u_fmul3_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .result(result), .ext_bits(ext_bits),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    // {op_a, op_b, result, ext_bits, ovf, unf}
    localparam int N = 18;
    localparam logic [121:0] VEC [N] = '{
        {32'h3FC00000, 32'h3FC00000, 32'h40100000, 24'h000000, 1'b0, 1'b0},
        {32'h3F800000, 32'h3F800000, 32'h3F800000, 24'h000000, 1'b0, 1'b0},
        {32'hC0000000, 32'h40400000, 32'hC0C00000, 24'h000000, 1'b0, 1'b0},
        {32'h3F800001, 32'h3F800001, 32'h3F800002, 24'h000002, 1'b0, 1'b0},
        {32'h3FC00001, 32'h3FC00000, 32'h40100000, 24'hC00000, 1'b0, 1'b0},
        {32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFE, 24'h000001, 1'b0, 1'b0},
        {32'h7F000000, 32'h40000000, 32'h7F800000, 24'h000000, 1'b1, 1'b0},
        {32'hFF000000, 32'h40000000, 32'hFF800000, 24'h000000, 1'b1, 1'b0},
        {32'h7F400000, 32'h3FC00000, 32'h7F800000, 24'h000000, 1'b1, 1'b0},
        {32'h7F000000, 32'h3F800000, 32'h7F000000, 24'h000000, 1'b0, 1'b0},
        {32'h00800000, 32'h3F000000, 32'h00000000, 24'h000000, 1'b0, 1'b1},
        {32'h80800000, 32'h3F000000, 32'h80000000, 24'h000000, 1'b0, 1'b1},
        {32'h00C00000, 32'h3F400000, 32'h00900000, 24'h000000, 1'b0, 1'b0},
        {32'h00800000, 32'h00800000, 32'h00000000, 24'h000000, 1'b0, 1'b1},
        {32'h00000000, 32'h7F000000, 32'h00000000, 24'h000000, 1'b0, 1'b0},
        {32'h80000001, 32'h40000000, 32'h80000000, 24'h000000, 1'b0, 1'b0},
        {32'h00000000, 32'h00800000, 32'h00000000, 24'h000000, 1'b0, 1'b0},
        {32'hBF800000, 32'hBF800000, 32'h3F800000, 24'h000000, 1'b0, 1'b0}
    };

    function automatic string row_req(input int i);
        case (i)
            0:       return "R4";
            1:       return "R1";
            2, 17:   return "R3";
            3:       return "R5";
            4, 5:    return "R6";
            6, 7, 8, 9:       return "R7";
            10, 11, 12, 13:   return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 reset", {out_valid, result, ext_bits, ovf_flag, unf_flag},
              {1'b1 & 1'b0, 32'h0, 24'h0, 1'b0, 1'b0});
        rst = 1'b0;

        // Table walked back to back: result of row j-3 checked when row j is driven (R2)
        for (int j = 0; j < N + 3; j++) begin
            @(negedge clk);
            if (j >= 3) begin
                check({row_req(j-3), " row"},
                      {out_valid, result, ext_bits, ovf_flag, unf_flag},
                      {1'b1, VEC[j-3][57:0]});
            end
            in_valid = (j < N);
            op_a     = (j < N) ? VEC[j][121:90] : 32'h0;
            op_b     = (j < N) ? VEC[j][89:58]  : 32'h0;
        end
        @(negedge clk);
        check("R2 drain", {63'h0, out_valid}, 64'h0);

        // R2: single pulse latency
        in_valid = 1'b1; op_a = 32'h40000000; op_b = 32'h40000000;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 lat1", {63'h0, out_valid}, 64'h0);
        @(negedge clk);
        check("R2 lat2", {63'h0, out_valid}, 64'h0);
        @(negedge clk);
        check("R2 lat3", {31'h0, out_valid, result}, {31'h0, 1'b1, 32'h40800000});
        @(negedge clk);
        check("R2 lat4", {63'h0, out_valid}, 64'h0);

        // R11: idle cycles with overflowing and underflowing operands
        op_a = 32'h7F000000; op_b = 32'h7F000000;
        repeat (4) @(negedge clk);
        check("R11 idle ovf", {62'h0, ovf_flag, unf_flag}, 64'h0);
        op_a = 32'h00800000; op_b = 32'h00800000;
        repeat (4) @(negedge clk);
        check("R11 idle unf", {62'h0, ovf_flag, unf_flag}, 64'h0);

        // R10: reset while an operand is in flight
        in_valid = 1'b1; op_a = 32'h7F000000; op_b = 32'h40000000;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 flush0", {out_valid, result, ext_bits, ovf_flag, unf_flag}, 64'h0);
        @(negedge clk);
        check("R10 flush1", {62'h0, out_valid, ovf_flag}, 64'h0);
        @(negedge clk);
        check("R10 flush2", {62'h0, out_valid, ovf_flag}, 64'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule